// File: doc/BRIEF.md
# Double-Buffered Cell Receive Buffer

This block takes fixed-length cells from one 4-bit receive port and hands them to logic on the system clock. The port has its own free-running data clock, which is unrelated to the system clock, plus a data-enable and a start-of-cell strobe. Nibbles are paired into bytes and written into one of two cell slots. A finished cell can then be read byte by byte on the system clock while the next cell is already being written into the other slot.

The cell length is set by a small select field and ranges from 52 to 56 bytes. The block recognises a cell cut off by an early start strobe (short) and surplus nibbles after the last byte (long). It drops a cell that arrives while both slots are still held (overflow). Each of these raises a sticky flag on the system side.

Slot-filled and slot-released events cross between the two clocks as toggles through two-flop synchronizers. The error events cross the same way.

Top module: `cellrx_buffer`

## Requirements
- R1: `cfg_len` selects the cell size: codes 0, 1, 2, 3 and 4 give 52, 53, 54, 55 and 56 bytes, and codes 5 to 7 give 56 bytes. A cell is complete after exactly that many bytes.
- R2: Each byte is built from two accepted nibbles, the first one forming bits 7:4. Byte k of the presented cell (k counted from 0 at the start strobe) appears on `rd_data` while `rd_addr` equals k.
- R3: `rd_ready` rises no later than the third rising `sclk` edge after the `pclk` edge that accepts the final nibble of a cell.
- R4: Two complete cells can be held at once. While the first is unreleased, the second is fully received, and the cells are presented in arrival order.
- R5: A one-cycle `rd_release` while `rd_ready` is high frees the presented slot, and the next held cell (if any) is presented. `rd_release` while `rd_ready` is low changes nothing.
- R6: A start strobe that arrives before the current cell is complete discards the partial cell, sets `st_short`, and begins a new cell with that nibble.
- R7: Nibbles accepted after a cell completes and before the next start strobe are dropped and set `st_long`. The completed cell is delivered unchanged.
- R8: A cell whose start strobe arrives while both slots are held is not stored. On completion it sets `st_ovf`, and the two held cells stay intact.
- R9: `st_short`, `st_long` and `st_ovf` stay high until a one-cycle `stat_rd` pulse, which clears them at the following `sclk` edge.
- R10: After reset, `rd_ready`, `st_short`, `st_long` and `st_ovf` are low.
- R11: Cycles with `rx_en` low are ignored. Accepted nibbles without a start strobe before the first cell after reset are ignored, with no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| pclk | input | 1 | Receive port data clock |
| rx_en | input | 1 | Nibble valid on this `pclk` cycle |
| rx_sof | input | 1 | Start-of-cell strobe, valid with `rx_en` |
| rx_nib | input | 4 | Receive nibble |
| sclk | input | 1 | System clock |
| cfg_len | input | 3 | Cell length select (static while cells flow) |
| rd_addr | input | 6 | Byte index into the presented cell |
| rd_data | output | 8 | Byte of the presented cell at `rd_addr` |
| rd_ready | output | 1 | A complete cell is presented |
| rd_release | input | 1 | Free the presented cell |
| stat_rd | input | 1 | Status read: clears the sticky flags |
| st_short | output | 1 | Sticky: short cell seen |
| st_long | output | 1 | Sticky: long cell seen |
| st_ovf | output | 1 | Sticky: cell dropped, both slots held |

## Verification
A cell's completion reaches `rd_ready` through two `sclk` flops, so it is visible at most three rising `sclk` edges after the last nibble. The bench polls `rd_ready` for four falling edges after that nibble's `pclk` edge. Error flags take the same path, and the bench samples them six `sclk` cycles after the offending nibble. A `stat_rd` clear and an `rd_release` act at the next `sclk` edge, and the bench reads the result at the falling edge after it. Read data is combinational from `rd_addr`, so the scoreboard samples it 1 ns after setting the address.

// File: rtl/cellrx_pkg.sv
package cellrx_pkg;
  localparam int unsigned NIB_W     = 4;
  localparam int unsigned BYTE_W    = 2 * NIB_W;
  localparam int unsigned MIN_LEN   = 52;
  localparam int unsigned MAX_LEN   = 56;
  localparam int unsigned LEN_SEL_W = 3;
  localparam int unsigned CNT_W     = $clog2(MAX_LEN + 1);
  localparam int unsigned ADDR_W    = $clog2(MAX_LEN);
  localparam int unsigned SLOTS     = 2;
  localparam int unsigned EV_W      = 3;
  localparam int unsigned EV_SHORT  = 0;
  localparam int unsigned EV_LONG   = 1;
  localparam int unsigned EV_OVF    = 2;

  typedef enum logic [1:0] {RX_IDLE, RX_BODY, RX_DONE, RX_DROP} rx_state_e;

  // Select code to byte count; codes past the top size saturate.
  function automatic logic [CNT_W-1:0] cell_bytes(input logic [LEN_SEL_W-1:0] sel);
    if (sel > LEN_SEL_W'(MAX_LEN - MIN_LEN)) return CNT_W'(MAX_LEN);
    return CNT_W'(MIN_LEN) + CNT_W'(sel);
  endfunction
endpackage

// File: rtl/cellrx_sync.sv
// Two-flop synchronizer, one bit per lane; with d tied high it releases a reset.
module cellrx_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      q    <= '0;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/cellrx_assem.sv
// Port-clock side: framing, nibble pairing, slot choice and error events.
module cellrx_assem
  import cellrx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LEN_SEL_W-1:0] len_sel,
  input  logic                 rx_en,
  input  logic                 rx_sof,
  input  logic [NIB_W-1:0]     rx_nib,
  input  logic [SLOTS-1:0]     rel_sync,
  output logic [SLOTS-1:0]     fill_tgl,
  output logic [EV_W-1:0]      ev_tgl,
  output logic                 wr_en,
  output logic                 wr_buf,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [BYTE_W-1:0]    wr_byte
);
  rx_state_e          st_q, st_d;
  logic [CNT_W-1:0]   bcnt_q, bcnt_d;
  logic               ph_q, ph_d;
  logic [NIB_W-1:0]   hi_q, hi_d;
  logic               wb_q, wb_d;
  logic               acc_q, acc_d;
  logic [SLOTS-1:0]   fill_q, fill_d;
  logic [EV_W-1:0]    evt_q, evt_d;
  logic [SLOTS-1:0]   occ;
  logic [CNT_W-1:0]   len;
  logic               commit;

  assign len = cell_bytes(len_sel);
  // A slot is held from its fill until the reader's release toggle comes back.
  assign occ = fill_q ^ rel_sync;

  always_comb begin
    st_d   = st_q;
    bcnt_d = bcnt_q;
    ph_d   = ph_q;
    hi_d   = hi_q;
    wb_d   = wb_q;
    acc_d  = acc_q;
    fill_d = fill_q;
    evt_d  = evt_q;
    wr_en  = 1'b0;
    commit = 1'b0;
    if (rx_en) begin
      if (rx_sof) begin
        if (st_q == RX_BODY) evt_d[EV_SHORT] = ~evt_q[EV_SHORT];
        st_d   = RX_BODY;
        bcnt_d = '0;
        ph_d   = 1'b1;
        hi_d   = rx_nib;
        acc_d  = ~occ[wb_q];
      end else begin
        unique case (st_q)
          RX_BODY: begin
            if (!ph_q) begin
              hi_d = rx_nib;
              ph_d = 1'b1;
            end else begin
              ph_d   = 1'b0;
              wr_en  = acc_q;
              bcnt_d = bcnt_q + CNT_W'(1);
              if (bcnt_q + CNT_W'(1) == len) begin
                st_d = RX_DONE;
                if (acc_q) begin
                  commit       = 1'b1;
                  fill_d[wb_q] = ~fill_q[wb_q];
                  wb_d         = ~wb_q;
                end else begin
                  evt_d[EV_OVF] = ~evt_q[EV_OVF];
                end
              end
            end
          end
          RX_DONE: begin
            evt_d[EV_LONG] = ~evt_q[EV_LONG];
            st_d           = RX_DROP;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      bcnt_q <= '0;
      ph_q   <= 1'b0;
      hi_q   <= '0;
      wb_q   <= 1'b0;
      acc_q  <= 1'b0;
      fill_q <= '0;
      evt_q  <= '0;
    end else if (rx_en) begin
      st_q   <= st_d;
      bcnt_q <= bcnt_d;
      ph_q   <= ph_d;
      hi_q   <= hi_d;
      wb_q   <= wb_d;
      acc_q  <= acc_d;
      fill_q <= fill_d;
      evt_q  <= evt_d;
    end
  end

  assign fill_tgl = fill_q;
  assign ev_tgl   = evt_q;
  assign wr_buf   = wb_q;
  assign wr_addr  = bcnt_q[ADDR_W-1:0];
  assign wr_byte  = {hi_q, rx_nib};

  // R8: a cell is only ever committed into a slot the reader does not hold.
  p_commit_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !occ[wb_q]);
  // R1: the byte counter never reaches the cell size while a cell is open.
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_BODY) |-> (bcnt_q < len));
  // R4: a slot only becomes full at the end of an open cell.
  p_fill_from_body_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q != $past(fill_q)) |-> ($past(st_q) == RX_BODY));
  // R7: a long-cell event leaves the framer discarding until the next strobe.
  p_long_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q[EV_LONG] != $past(evt_q[EV_LONG])) |-> (st_q == RX_DROP));
endmodule

// File: rtl/cellrx_drain.sv
// System-clock side: presented slot, release toggles and sticky error flags.
module cellrx_drain
  import cellrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] fill_sync,
  input  logic [EV_W-1:0]  ev_sync,
  input  logic             rd_release,
  input  logic             stat_rd,
  output logic [SLOTS-1:0] rel_tgl,
  output logic             rd_buf,
  output logic             rd_ready,
  output logic [EV_W-1:0]  flags
);
  logic             rb_q, rb_d;
  logic [SLOTS-1:0] rel_q, rel_d;
  logic [EV_W-1:0]  evp_q;
  logic [EV_W-1:0]  flg_q, flg_d;
  logic [SLOTS-1:0] full;
  logic [EV_W-1:0]  ev_hit;

  assign full     = fill_sync ^ rel_q;
  assign rd_ready = full[rb_q];
  assign ev_hit   = ev_sync ^ evp_q;

  always_comb begin
    rb_d  = rb_q;
    rel_d = rel_q;
    if (rd_release && rd_ready) begin
      rel_d[rb_q] = ~rel_q[rb_q];
      rb_d        = ~rb_q;
    end
    // A new event wins over a clear in the same cycle.
    flg_d = (stat_rd ? '0 : flg_q) | ev_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q  <= 1'b0;
      rel_q <= '0;
      evp_q <= '0;
      flg_q <= '0;
    end else begin
      rb_q  <= rb_d;
      rel_q <= rel_d;
      evp_q <= ev_sync;
      flg_q <= flg_d;
    end
  end

  assign rel_tgl = rel_q;
  assign rd_buf  = rb_q;
  assign flags   = flg_q;

  // R5: a presented cell only goes away through a release.
  p_ready_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_ready) |-> $past(rd_release));
  // R5: a release with nothing presented leaves the read slot alone.
  p_idle_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_release && !rd_ready) |=> $stable(rb_q));
  // R9: a raised flag stays up until a status read.
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((flg_q != '0) && !stat_rd) |=> ((flg_q & $past(flg_q)) == $past(flg_q)));
  // R9: a status read with no new event empties the flags.
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && (ev_hit == '0)) |=> (flg_q == '0));
endmodule

// File: rtl/cellrx_buffer.sv
module cellrx_buffer
  import cellrx_pkg::*;
(
  input  logic                 rst_n,
  input  logic                 pclk,
  input  logic                 rx_en,
  input  logic                 rx_sof,
  input  logic [NIB_W-1:0]     rx_nib,
  input  logic                 sclk,
  input  logic [LEN_SEL_W-1:0] cfg_len,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [BYTE_W-1:0]    rd_data,
  output logic                 rd_ready,
  input  logic                 rd_release,
  input  logic                 stat_rd,
  output logic                 st_short,
  output logic                 st_long,
  output logic                 st_ovf
);
  logic              p_rst_n, s_rst_n;
  logic [SLOTS-1:0]  fill_tgl, fill_s, rel_tgl, rel_p;
  logic [EV_W-1:0]   ev_tgl, ev_s, flags;
  logic              wr_en, wr_buf, rd_buf;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_byte;
  logic [BYTE_W-1:0] mem_q [SLOTS][MAX_LEN];

  cellrx_sync #(.W(1)) u_prst (.clk(pclk), .rst_n(rst_n), .d(1'b1), .q(p_rst_n));
  cellrx_sync #(.W(1)) u_srst (.clk(sclk), .rst_n(rst_n), .d(1'b1), .q(s_rst_n));

  cellrx_assem u_assem (
    .clk(pclk), .rst_n(p_rst_n), .len_sel(cfg_len),
    .rx_en(rx_en), .rx_sof(rx_sof), .rx_nib(rx_nib),
    .rel_sync(rel_p), .fill_tgl(fill_tgl), .ev_tgl(ev_tgl),
    .wr_en(wr_en), .wr_buf(wr_buf), .wr_addr(wr_addr), .wr_byte(wr_byte)
  );

  cellrx_sync #(.W(SLOTS)) u_fill_s (.clk(sclk), .rst_n(s_rst_n), .d(fill_tgl), .q(fill_s));
  cellrx_sync #(.W(EV_W))  u_ev_s   (.clk(sclk), .rst_n(s_rst_n), .d(ev_tgl),   .q(ev_s));
  cellrx_sync #(.W(SLOTS)) u_rel_p  (.clk(pclk), .rst_n(p_rst_n), .d(rel_tgl),  .q(rel_p));

  cellrx_drain u_drain (
    .clk(sclk), .rst_n(s_rst_n), .fill_sync(fill_s), .ev_sync(ev_s),
    .rd_release(rd_release), .stat_rd(stat_rd),
    .rel_tgl(rel_tgl), .rd_buf(rd_buf), .rd_ready(rd_ready), .flags(flags)
  );

  // Slot storage: written on the port clock, read only once the slot is handed over.
  always_ff @(posedge pclk) begin
    if (wr_en) mem_q[wr_buf][wr_addr] <= wr_byte;
  end

  assign rd_data  = (rd_addr < ADDR_W'(MAX_LEN)) ? mem_q[rd_buf][rd_addr] : '0;
  assign st_short = flags[EV_SHORT];
  assign st_long  = flags[EV_LONG];
  assign st_ovf   = flags[EV_OVF];
endmodule

// File: tb/test_cellrx_buffer.sv
`timescale 1ns/1ps
module test_cellrx_buffer;
  localparam int MAXB = 56;

  logic       rst_n, pclk, sclk, rx_en, rx_sof, rd_ready, rd_release, stat_rd;
  logic       st_short, st_long, st_ovf;
  logic [3:0] rx_nib;
  logic [2:0] cfg_len;
  logic [5:0] rd_addr;
  logic [7:0] rd_data;

  int  n_checks = 0, n_err = 0, seed = 1;
  bit  mon_on = 0, done = 0;
  logic [8*MAXB-1:0] exp_q[$];
  int                len_q[$];
  string             tag_q[$];

  cellrx_buffer i_cellrx_buffer (
    .rst_n(rst_n), .pclk(pclk), .rx_en(rx_en), .rx_sof(rx_sof), .rx_nib(rx_nib),
    .sclk(sclk), .cfg_len(cfg_len), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_ready(rd_ready), .rd_release(rd_release), .stat_rd(stat_rd),
    .st_short(st_short), .st_long(st_long), .st_ovf(st_ovf)
  );

  initial sclk = 0;
  always #2.5 sclk = ~sclk;
  initial pclk = 0;
  always #3.5 pclk = ~pclk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: build a cell, push it to the scoreboard if it must arrive, send it.
  task automatic send_cell(input int nbytes, input int extra, input bit keep,
                           input bit gaps, input string req);
    logic [8*MAXB-1:0] c;
    c = '0;
    for (int j = 0; j < nbytes; j++) c[8*j +: 8] = 8'(seed * 37 + j * 5 + 3);
    seed++;
    if (keep) begin
      exp_q.push_back(c); len_q.push_back(nbytes); tag_q.push_back(req);
    end
    for (int k = 0; k < 2 * nbytes + extra; k++) begin
      @(negedge pclk);
      if (gaps && (k % 7 == 3)) begin
        rx_en = 0; rx_sof = 0; rx_nib = 4'hA;
        @(negedge pclk);
      end
      rx_en  = 1;
      rx_sof = (k == 0);
      if (k < 2 * nbytes) rx_nib = (k % 2 == 0) ? c[8*(k/2)+4 +: 4] : c[8*(k/2) +: 4];
      else                rx_nib = 4'h5;
    end
    @(negedge pclk);
    rx_en = 0; rx_sof = 0;
  endtask

  task automatic wait_s(input int n);
    repeat (n) @(negedge sclk);
  endtask

  task automatic wait_drain(input string req);
    int t;
    t = 0;
    while ((exp_q.size() != 0 || rd_ready) && t < 3000) begin
      @(negedge sclk); t++;
    end
    check(exp_q.size() == 0, req, "cells still expected", exp_q.size(), 0);
  endtask

  task automatic pulse_stat();
    @(negedge sclk); stat_rd = 1;
    @(negedge sclk); stat_rd = 0;
  endtask

  // Monitor: pop the oldest expected cell and compare every byte.
  initial begin
    forever begin
      @(negedge sclk);
      if (mon_on && rd_ready) begin
        logic [8*MAXB-1:0] c;
        int n, bad, first_bad;
        string tg;
        if (exp_q.size() == 0) begin
          check(0, "R4", "unexpected cell presented", 1, 0);
        end else begin
          c = exp_q.pop_front(); n = len_q.pop_front(); tg = tag_q.pop_front();
          bad = 0; first_bad = -1;
          for (int j = 0; j < n; j++) begin
            rd_addr = 6'(j);
            #1;
            if (rd_data !== c[8*j +: 8]) begin
              bad++;
              if (first_bad < 0) first_bad = j;
            end
          end
          check(bad == 0, tg, "byte mismatches in cell (R2 order)", bad, 0);
        end
        @(negedge sclk); rd_release = 1;
        @(negedge sclk); rd_release = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge sclk);
    if (!done) begin
      check(0, "watchdog", "run did not finish", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_en = 0; rx_sof = 0; rx_nib = 0; cfg_len = 0;
    rd_addr = 0; rd_release = 0; stat_rd = 0;
    wait_s(6);
    rst_n = 1;
    wait_s(4);

    // R10: reset state
    check(rd_ready == 0, "R10", "rd_ready after reset", rd_ready, 0);
    check({st_short, st_long, st_ovf} == 3'b000, "R10", "flags after reset",
          {st_short, st_long, st_ovf}, 0);

    // R11: stray nibbles before any strobe; R5: release with nothing held
    for (int k = 0; k < 10; k++) begin
      @(negedge pclk); rx_en = 1; rx_sof = 0; rx_nib = 4'(k);
    end
    @(negedge pclk); rx_en = 0;
    @(negedge sclk); rd_release = 1;
    @(negedge sclk); rd_release = 0;
    wait_s(6);
    check(rd_ready == 0, "R5", "rd_ready after idle release", rd_ready, 0);
    check({st_short, st_long, st_ovf} == 3'b000, "R11", "flags after stray nibbles",
          {st_short, st_long, st_ovf}, 0);

    // R3: latency of the ready indication, 52-byte cell
    cfg_len = 3'd0;
    send_cell(52, 0, 1, 0, "R1");
    begin
      int t;
      t = 0;
      while (!rd_ready && t < 4) begin @(negedge sclk); t++; end
      check(rd_ready == 1, "R3", "rd_ready within bound", rd_ready, 1);
    end
    mon_on = 1;
    wait_drain("R1");

    // R1: remaining size codes, with enable gaps on some (R11)
    for (int s = 1; s <= 7; s++) begin
      if (s == 5 || s == 6) continue;
      cfg_len = 3'(s);
      send_cell(s > 4 ? 56 : 52 + s, 0, 1, s % 2 == 1, "R1");
      wait_drain("R1");
    end
    wait_s(6);
    check({st_short, st_long, st_ovf} == 3'b000, "R11", "no flags after gapped cells",
          {st_short, st_long, st_ovf}, 0);

    // R4: two cells held together, drained in order
    cfg_len = 3'd2;
    mon_on = 0;
    send_cell(54, 0, 1, 0, "R4");
    send_cell(54, 0, 1, 0, "R4");
    wait_s(6);
    check(rd_ready == 1, "R4", "first cell presented", rd_ready, 1);
    check({st_short, st_long, st_ovf} == 3'b000, "R4", "no flags with two held",
          {st_short, st_long, st_ovf}, 0);
    mon_on = 1;
    wait_drain("R4");

    // R6: short cell followed by a good one
    send_cell(20, 0, 0, 0, "R6");
    send_cell(54, 0, 1, 0, "R6");
    wait_drain("R6");
    wait_s(6);
    check(st_short == 1, "R6", "st_short set", st_short, 1);
    check(st_long == 0, "R6", "st_long clear", st_long, 0);

    // R9: sticky, then cleared by a status read
    wait_s(10);
    check(st_short == 1, "R9", "st_short still held", st_short, 1);
    pulse_stat();
    @(negedge sclk);
    check(st_short == 0, "R9", "st_short cleared", st_short, 0);

    // R7: surplus nibbles after a complete cell
    send_cell(54, 6, 1, 0, "R7");
    wait_s(6);
    check(st_long == 1, "R7", "st_long set", st_long, 1);
    check(st_short == 0, "R7", "st_short clear", st_short, 0);
    wait_drain("R7");
    pulse_stat();
    @(negedge sclk);
    check(st_long == 0, "R9", "st_long cleared", st_long, 0);

    // R8: third cell while both slots held is dropped
    mon_on = 0;
    send_cell(54, 0, 1, 0, "R8");
    send_cell(54, 0, 1, 0, "R8");
    send_cell(54, 0, 0, 0, "R8");
    wait_s(6);
    check(st_ovf == 1, "R8", "st_ovf set", st_ovf, 1);
    mon_on = 1;
    wait_drain("R8");
    wait_s(6);
    check(rd_ready == 0, "R8", "nothing left after two cells", rd_ready, 0);
    pulse_stat();
    @(negedge sclk);
    check(st_ovf == 0, "R9", "st_ovf cleared", st_ovf, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule